// File: doc/BRIEF.md
# Bus Master Latency Timer

This block limits how long a bus-mastering peripheral may keep a parallel bus. Software programs an 8-bit timer register through a single-register configuration port. Only the upper four bits of that register set the time slice, in units of 16 bus clocks.

While the master drives its active-low framing signal, the block counts bus clocks. Once the programmed slice has run out, it raises a sticky expiry flag. The grant input is an active-low hold-acknowledge. While the grant stays active, the master may run any number of transactions without limit.

The termination request rises only when three things are true at the same clock edge:
- the slice has expired;
- the grant has been withdrawn;
- the transaction in progress reports its last cycle.

The bus is therefore never given up part-way through a transaction. Releasing the framing signal clears the counter, the expiry flag and the request.

Top module: `bus_latency_timer`

## Requirements
- R1: The timer register resets to 00h. A write takes effect at the rising edge where `cfg_sel` and `cfg_we` are both high. `cfg_rdata` shows the register while `cfg_sel` is high and reads 00h otherwise.
- R2: Register bits 3:0 are reserved. They always read 0, and written values in them do not affect the slice. The slice S is the value of bits 7:4 multiplied by 16 clocks.
- R3: A rising edge that samples `frame_n` high clears the count. By the next sample after that edge, `slice_expired` and `term_req` read 0.
- R4: `slice_expired` goes high after S+1 consecutive rising edges that sample `frame_n` low. It stays high until `frame_n` is sampled high.
- R5: A tenure that ends before expiry produces no termination. The next tenure starts its count from zero.
- R6: `term_req` goes high after a rising edge at which all of the following hold:
  - `frame_n` is low;
  - `slice_expired` is already high;
  - `hold_ack_n` is high;
  - `xfer_last` is high.

  Once high, it holds until `frame_n` is sampled high.
- R7: While `hold_ack_n` is low, `term_req` does not rise, however long the tenure and however many transactions complete.
- R8: An expired slice with the grant withdrawn does not raise `term_req` until a rising edge that samples `xfer_last` high.
- R9: With bits 7:4 equal to 0, `slice_expired` is high after the first rising edge that samples `frame_n` low. Termination follows at the first completion after the grant is withdrawn.
- R10: A write during a tenure changes the slice used for comparison from the following edge. The running count is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Timer register selected |
| cfg_we | input | 1 | Write strobe for the selected register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, combinational from the register |
| frame_n | input | 1 | Active-low master framing signal |
| hold_ack_n | input | 1 | Active-low grant (hold acknowledge) |
| xfer_last | input | 1 | Current transaction completes this cycle |
| slice_expired | output | 1 | Sticky slice-expired flag, registered |
| term_req | output | 1 | Registered termination request |

## Verification
`cfg_rdata` is combinational: a write is visible in the sample taken after its edge, and a change of `cfg_sel` shows at once. `slice_expired` and `term_req` are each one register behind the edge that samples their inputs. Expiry is therefore due in the sample after edge S+1 of the tenure, and a mid-tenure write first counts at the edge after the one that stored it.

The bench drives inputs at the falling edge and lets one rising edge pass. It then compares every output with its behavioural model at the next falling edge, so every result is read exactly one register stage after its cause. Directed checks count edges explicitly against these same delays.

// File: rtl/blt_pkg.sv
package blt_pkg;
  localparam int REG_W   = 8;
  localparam int RSV_W   = 4;
  localparam int SLICE_W = REG_W - RSV_W;
endpackage

// File: rtl/blt_cfg_reg.sv
module blt_cfg_reg #(
  parameter int W     = 8,
  parameter int RSV_W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [W-1:0] slice
);
  logic [W-1:0] mask;
  logic [W-1:0] regq;

  // Reserved low bits are masked out of storage, read data and the slice.
  for (genvar b = 0; b < W; b++) begin : g_mask
    if (b < RSV_W) begin : g_rsv
      assign mask[b] = 1'b0;
    end else begin : g_live
      assign mask[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      regq <= '0;
    else if (sel && we)
      regq <= wdata & mask;
  end

  assign slice = regq;
  assign rdata = sel ? regq : '0;
endmodule

// File: rtl/blt_slice_counter.sv
module blt_slice_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_n,
  input  logic [W-1:0] slice,
  output logic         expired
);
  logic [W-1:0] cnt;
  logic         reached;

  assign reached = (cnt >= slice);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (frame_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      // Saturate at the slice so the count never wraps.
      if (!reached)
        cnt <= cnt + 1'b1;
      if (reached)
        expired <= 1'b1;
    end
  end
endmodule

// File: rtl/blt_term_ctrl.sv
module blt_term_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic hold_ack_n,
  input  logic xfer_last,
  input  logic expired,
  output logic term_req
);
  logic fire;

  assign fire = expired && hold_ack_n && xfer_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      term_req <= 1'b0;
    else if (frame_n)
      term_req <= 1'b0;
    else if (fire)
      term_req <= 1'b1;
  end
endmodule

// File: rtl/bus_latency_timer.sv
module bus_latency_timer
  import blt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sel,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             frame_n,
  input  logic             hold_ack_n,
  input  logic             xfer_last,
  output logic             slice_expired,
  output logic             term_req
);
  logic [REG_W-1:0] slice;

  blt_cfg_reg #(.W(REG_W), .RSV_W(RSV_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (cfg_sel),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .slice (slice)
  );

  blt_slice_counter #(.W(REG_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .slice   (slice),
    .expired (slice_expired)
  );

  blt_term_ctrl u_term (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .hold_ack_n (hold_ack_n),
    .xfer_last  (xfer_last),
    .expired    (slice_expired),
    .term_req   (term_req)
  );
endmodule

// File: rtl/bus_latency_timer_chk.sv
module bus_latency_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_sel,
  input logic [7:0] cfg_rdata,
  input logic       frame_n,
  input logic       hold_ack_n,
  input logic       xfer_last,
  input logic       slice_expired,
  input logic       term_req
);
  // R2: reserved bits never read back as one
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3:0] == 4'h0);

  // R1: deselected port reads zero
  p_desel_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel |-> cfg_rdata == 8'h00);

  // R3: releasing the frame clears expiry and request
  p_release_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |=> !slice_expired && !term_req);

  // R4: expiry is sticky within a tenure
  p_exp_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slice_expired && !frame_n |=> slice_expired);

  // R6: the request needs expiry, withdrawn grant and a completion at the prior edge
  p_term_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_req) |-> $past(slice_expired) && $past(hold_ack_n) && $past(xfer_last));

  // R7: an active grant blocks a new request
  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n && !term_req |=> !term_req);

  // R6: request implies expiry
  p_term_needs_exp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |-> slice_expired);
endmodule

bind bus_latency_timer bus_latency_timer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_sel       (cfg_sel),
  .cfg_rdata     (cfg_rdata),
  .frame_n       (frame_n),
  .hold_ack_n    (hold_ack_n),
  .xfer_last     (xfer_last),
  .slice_expired (slice_expired),
  .term_req      (term_req)
);

// File: tb/bus_latency_timer_tb.sv
module bus_latency_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_sel = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       frame_n = 1'b1, hold_ack_n = 1'b0, xfer_last = 1'b0;
  logic       slice_expired, term_req;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_reg = 0, m_cnt = 0;
  bit m_exp = 0, m_term = 0;

  always #4 clk = ~clk;

  bus_latency_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_n(frame_n),
    .hold_ack_n(hold_ack_n), .xfer_last(xfer_last),
    .slice_expired(slice_expired), .term_req(term_req)
  );

  always @(posedge clk) begin
    int s;
    bit ne, nt;
    int nc;
    if (!rst_n) begin
      m_reg = 0; m_cnt = 0; m_exp = 0; m_term = 0;
    end else begin
      s = m_reg & 'hF0;
      if (frame_n) begin
        nc = 0; ne = 0; nt = 0;
      end else begin
        nt = m_term | (m_exp & hold_ack_n & xfer_last);
        ne = m_exp | (m_cnt >= s);
        nc = (m_cnt < s) ? m_cnt + 1 : m_cnt;
      end
      m_cnt = nc; m_exp = ne; m_term = nt;
      if (cfg_sel && cfg_we) m_reg = cfg_wdata & 'hF0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk("R1 rdata vs model", cfg_rdata, cfg_sel ? (m_reg & 'hF0) : 0);
    chk("R4 expired vs model", slice_expired, m_exp);
    chk("R6 term_req vs model", term_req, m_term);
  endtask

  // drive at falling edge, pass one rising edge, compare at next falling edge
  task automatic cyc(input bit f, input bit h, input bit l,
                     input bit s = 0, input bit w = 0, input logic [7:0] d = 8'h00);
    frame_n = f; hold_ack_n = h; xfer_last = l;
    cfg_sel = s; cfg_we = w; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    model_cmp();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 0, 1);
    chk("R1 reset value", cfg_rdata, 8'h00);
    cyc(1, 0, 0, 1, 1, 8'h1F);
    chk("R2 reserved read zero", cfg_rdata, 8'h10);
    cyc(1, 0, 0, 0);
    chk("R1 deselected reads zero", cfg_rdata, 8'h00);

    // S=16 under active grant with completions: no termination
    for (int i = 1; i <= 20; i++) begin
      cyc(0, 0, (i % 3) == 0);
      if (i == 16) chk("R4 not yet expired at edge 16", slice_expired, 0);
      if (i == 17) chk("R4 expired at edge 17", slice_expired, 1);
      chk("R7 no term while granted", term_req, 0);
    end
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 0);
      chk("R8 no term without completion", term_req, 0);
    end
    cyc(0, 1, 1);
    chk("R6 term after completion", term_req, 1);
    cyc(0, 0, 0);
    chk("R6 term holds", term_req, 1);
    cyc(1, 0, 0);
    chk("R3 release clears expiry", slice_expired, 0);
    chk("R3 release clears term", term_req, 0);

    // tenure ending before expiry
    for (int i = 1; i <= 5; i++) cyc(0, 1, i == 5);
    chk("R5 early finish no term", term_req, 0);
    cyc(1, 1, 0);
    for (int i = 1; i <= 17; i++) cyc(0, 0, 0);
    chk("R5 fresh count expires at 17", slice_expired, 1);
    cyc(1, 0, 0);

    // zero slice, reserved bits written
    cyc(1, 0, 0, 1, 1, 8'h05);
    chk("R2 write 05 reads 00", cfg_rdata, 8'h00);
    cyc(0, 1, 1);
    chk("R9 immediate expiry", slice_expired, 1);
    chk("R9 no term on first edge", term_req, 0);
    cyc(0, 1, 1);
    chk("R9 term at first completion", term_req, 1);
    cyc(1, 0, 0);

    // mid-tenure write to a smaller slice
    cyc(1, 0, 0, 1, 1, 8'hF0);
    for (int i = 1; i <= 10; i++) cyc(0, 0, 0);
    cyc(0, 0, 0, 1, 1, 8'h00);
    chk("R10 not expired at write edge", slice_expired, 0);
    cyc(0, 0, 0);
    chk("R10 expired edge after write", slice_expired, 1);
    cyc(1, 0, 0);

    // mid-tenure write to a larger slice: count continues (S=32 -> edge 33)
    cyc(1, 0, 0, 1, 1, 8'h10);
    for (int i = 1; i <= 10; i++) cyc(0, 0, 0);
    cyc(0, 0, 0, 1, 1, 8'h20);
    for (int i = 12; i <= 33; i++) begin
      cyc(0, 0, 0);
      if (i == 32) chk("R10 not expired at edge 32", slice_expired, 0);
    end
    chk("R10 count kept, expired at 33", slice_expired, 1);
    cyc(1, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule